// File: doc/BRIEF.md
# Windowed Integer Register File

This block gives a core 32 architectural integer registers and places them over a larger physical store through a sliding window. The caller supplies the current window pointer with every access. Each 5-bit register index is turned into a physical slot from that pointer and the index's bank. Eight globals are common to every window. Each window has eight private locals. The eight output registers of a window are the same storage as the eight input registers of the window one below it, modulo the window count. A caller can therefore leave arguments in its outputs, move the pointer down by one, and the callee finds them in its inputs without any copy.

The store is sized at 8 + 16·NWIN words. Each window owns its locals and its outputs. Its inputs reuse the outputs of the next window up. There are two combinational read ports and one write port that updates on the clock edge. Index 0 is a constant zero. Software conventions put the stack pointer in output 6 and the frame pointer in input 6, and keep the return address in input 7. The hardware treats these like any other register. Moving the window pointer, raising spill traps and floating-point state are handled elsewhere.

Top module: `wrf_regfile`

## Requirements
- R1: After reset, every index in every window reads zero on both read ports.
- R2: Index 0 reads zero on both ports in every window, and a write to index 0 is discarded.
- R3: With wr_en high at a rising edge, wr_data is stored at the slot that (wr_win, wr_idx) selects. It is readable from the next cycle at the same (window, index). A slot that is not written keeps its value.
- R4: Output register k (index 8+k) of window w is the same storage as input register k (index 24+k) of window (w−1) mod NWIN, and this includes the wrap from window 0 to window NWIN−1. The inputs of a window are not its own outputs.
- R5: Locals (indices 16–23) are private to each window. A write to a local in one window leaves the same index in every other window unchanged.
- R6: Globals (indices 1–7) are one set of storage, so a value written in any window is read back in all windows.
- R7: A read of a slot in the same cycle it is being written returns the old value. The new value appears after the edge.
- R8: The read ports are combinational and independent. Changing a read index or read window changes that port's data without a clock edge, and the other port is not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears the store |
| rd_win_a | input | log2(NWIN) | Window pointer for read port A |
| rd_idx_a | input | 5 | Architectural index for read port A |
| rd_data_a | output | XLEN | Read data, port A |
| rd_win_b | input | log2(NWIN) | Window pointer for read port B |
| rd_idx_b | input | 5 | Architectural index for read port B |
| rd_data_b | output | XLEN | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_win | input | log2(NWIN) | Window pointer for the write |
| wr_idx | input | 5 | Architectural index for the write |
| wr_data | input | XLEN | Write data |

## Verification
A fault in the index translation shows on a read port in the cycle after the write it affects. The value appears under the wrong (window, index) pair, or it is missing from the partner window across the output/input overlap. Most of the directed tests are therefore a write in one window followed by a read in a neighbouring or distant window. A stored word that has been corrupted stays corrupted until it is next written. It is seen only when some later read selects that slot, so the bench reads back every bank after writing to it, and includes the wrap from window 0 to the highest window.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int unsigned ARCH_W    = 5;
  localparam int unsigned BANK_REGS = 8;
  localparam int unsigned GLOB_REGS = BANK_REGS;
  localparam int unsigned WIN_FRAME = 2 * BANK_REGS; // locals + outs per window

  typedef enum logic [1:0] {
    BANK_GLOBAL = 2'd0,
    BANK_OUT    = 2'd1,
    BANK_LOCAL  = 2'd2,
    BANK_IN     = 2'd3
  } bank_e;
endpackage

// File: rtl/wrf_index_map.sv
module wrf_index_map
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  localparam int unsigned WPW   = $clog2(NWIN),
  localparam int unsigned DEPTH = GLOB_REGS + WIN_FRAME * NWIN,
  localparam int unsigned PW    = $clog2(DEPTH)
) (
  input  logic [WPW-1:0]    win,
  input  logic [ARCH_W-1:0] idx,
  output logic [PW-1:0]     phys
);
  function automatic logic [PW-1:0] slot_of(input logic [WPW-1:0] w,
                                            input logic [ARCH_W-1:0] a);
    int unsigned off, cur, nxt, slot;
    off  = 32'(a[2:0]);
    cur  = 32'(w);
    nxt  = 32'(WPW'(w + WPW'(1)));   // ins live in the outs of window w+1
    slot = 0;
    unique case (bank_e'(a[4:3]))
      BANK_GLOBAL: slot = off;
      BANK_OUT:    slot = GLOB_REGS + WIN_FRAME * cur + BANK_REGS + off;
      BANK_LOCAL:  slot = GLOB_REGS + WIN_FRAME * cur + off;
      BANK_IN:     slot = GLOB_REGS + WIN_FRAME * nxt + BANK_REGS + off;
      default:     slot = 0;
    endcase
    return PW'(slot);
  endfunction

  assign phys = slot_of(win, idx);
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int unsigned DEPTH = 136,
  parameter int unsigned AW    = 8,
  parameter int unsigned XLEN  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [AW-1:0]   ra_a,
  output logic [XLEN-1:0] rd_a,
  input  logic [AW-1:0]   ra_b,
  output logic [XLEN-1:0] rd_b
);
  logic [XLEN-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                      words[i] <= '0;
      else if (we && wa == AW'(i))     words[i] <= wd;
    end
  end

  assign rd_a = words[ra_a];
  assign rd_b = words[ra_b];
endmodule

// File: rtl/wrf_regfile.sv
module wrf_regfile
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32,
  localparam int unsigned WPW   = $clog2(NWIN),
  localparam int unsigned DEPTH = GLOB_REGS + WIN_FRAME * NWIN,
  localparam int unsigned PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WPW-1:0]    rd_win_a,
  input  logic [ARCH_W-1:0] rd_idx_a,
  output logic [XLEN-1:0]   rd_data_a,
  input  logic [WPW-1:0]    rd_win_b,
  input  logic [ARCH_W-1:0] rd_idx_b,
  output logic [XLEN-1:0]   rd_data_b,
  input  logic              wr_en,
  input  logic [WPW-1:0]    wr_win,
  input  logic [ARCH_W-1:0] wr_idx,
  input  logic [XLEN-1:0]   wr_data
);
  logic [PW-1:0]   phys_a, phys_b, phys_w;
  logic [XLEN-1:0] raw_a, raw_b;
  logic            wr_fire;   // a write that really lands in the store

  wrf_index_map #(.NWIN(NWIN)) u_map_a (.win(rd_win_a), .idx(rd_idx_a), .phys(phys_a));
  wrf_index_map #(.NWIN(NWIN)) u_map_b (.win(rd_win_b), .idx(rd_idx_b), .phys(phys_b));
  wrf_index_map #(.NWIN(NWIN)) u_map_w (.win(wr_win),   .idx(wr_idx),   .phys(phys_w));

  assign wr_fire = wr_en && (wr_idx != '0);

  wrf_storage #(.DEPTH(DEPTH), .AW(PW), .XLEN(XLEN)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_fire),
    .wa   (phys_w),
    .wd   (wr_data),
    .ra_a (phys_a),
    .rd_a (raw_a),
    .ra_b (phys_b),
    .rd_b (raw_b)
  );

  assign rd_data_a = (rd_idx_a == '0) ? '0 : raw_a;
  assign rd_data_b = (rd_idx_b == '0) ? '0 : raw_b;
endmodule

// File: rtl/wrf_regfile_chk.sv
module wrf_regfile_chk
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned XLEN  = 32,
  parameter int unsigned DEPTH = 136,
  parameter int unsigned PW    = 8,
  localparam int unsigned WPW  = $clog2(NWIN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WPW-1:0]    rd_win_a,
  input logic [ARCH_W-1:0] rd_idx_a,
  input logic [XLEN-1:0]   rd_data_a,
  input logic [WPW-1:0]    rd_win_b,
  input logic [ARCH_W-1:0] rd_idx_b,
  input logic [XLEN-1:0]   rd_data_b,
  input logic              wr_fire,
  input logic [WPW-1:0]    wr_win,
  input logic [ARCH_W-1:0] wr_idx,
  input logic [XLEN-1:0]   wr_data,
  input logic [PW-1:0]     phys_a,
  input logic [PW-1:0]     phys_w
);
  AST_ZERO_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx_a == '0 |-> rd_data_a == '0); // R2
  AST_ZERO_PORT_B: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx_b == '0 |-> rd_data_b == '0); // R2
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_fire) && rd_win_a == $past(wr_win) && rd_idx_a == $past(wr_idx)
    |-> rd_data_a == $past(wr_data)); // R3
  AST_OUT_FEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_fire) && $past(wr_idx[4:3]) == 2'b01
    && rd_idx_b == {2'b11, $past(wr_idx[2:0])}
    && rd_win_b == WPW'($past(wr_win) - WPW'(1))
    |-> rd_data_b == $past(wr_data)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(wr_fire) && $stable(rd_win_a) && $stable(rd_idx_a)
    |-> $stable(rd_data_a)); // R3
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(phys_a) < DEPTH && 32'(phys_w) < DEPTH); // R4
endmodule

bind wrf_regfile wrf_regfile_chk #(
  .NWIN(NWIN), .XLEN(XLEN), .DEPTH(DEPTH), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_win_a(rd_win_a), .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
  .rd_win_b(rd_win_b), .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
  .wr_fire(wr_fire), .wr_win(wr_win), .wr_idx(wr_idx), .wr_data(wr_data),
  .phys_a(phys_a), .phys_w(phys_w)
);

// File: tb/wrf_regfile_tb.sv
module wrf_regfile_tb;
  localparam int unsigned NWIN = 8;
  localparam int unsigned XLEN = 32;
  localparam int unsigned WPW  = $clog2(NWIN);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [WPW-1:0]  rd_win_a = '0, rd_win_b = '0, wr_win = '0;
  logic [4:0]      rd_idx_a = '0, rd_idx_b = '0, wr_idx = '0;
  logic [XLEN-1:0] rd_data_a, rd_data_b, wr_data = '0;
  logic            wr_en = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  wrf_regfile #(.NWIN(NWIN), .XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_win_a(rd_win_a), .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
    .rd_win_b(rd_win_b), .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_win(wr_win), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one write, inputs changed at the falling edge
  task automatic put(input int w, input int i, input logic [XLEN-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_win = WPW'(w); wr_idx = 5'(i); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic get_a(input int w, input int i, output logic [XLEN-1:0] d);
    rd_win_a = WPW'(w); rd_idx_a = 5'(i);
    #1 d = rd_data_a;
  endtask

  task automatic get_b(input int w, input int i, output logic [XLEN-1:0] d);
    rd_win_b = WPW'(w); rd_idx_b = 5'(i);
    #1 d = rd_data_b;
  endtask

  task automatic t_reset_r1();
    logic [XLEN-1:0] v;
    @(negedge clk);
    for (int w = 0; w < NWIN; w += 3)
      for (int i = 0; i < 32; i++) begin
        get_a(w, i, v); check("R1 port A after reset", v, '0);
        get_b(w, i, v); check("R1 port B after reset", v, '0);
      end
  endtask

  task automatic t_zero_r2();
    logic [XLEN-1:0] v;
    put(3, 0, 32'hDEAD_BEEF);
    get_a(3, 0, v); check("R2 index 0 port A", v, '0);
    get_b(6, 0, v); check("R2 index 0 port B", v, '0);
  endtask

  task automatic t_write_r3();
    logic [XLEN-1:0] v;
    put(2, 17, 32'h1111_2222);
    get_a(2, 17, v); check("R3 write visible port A", v, 32'h1111_2222);
    get_b(2, 17, v); check("R3 write visible port B", v, 32'h1111_2222);
    get_a(2, 18, v); check("R3 neighbour slot untouched", v, '0);
  endtask

  task automatic t_alias_r4();
    logic [XLEN-1:0] v;
    put(5, 14, 32'h5A5A_0006);           // out 6 of window 5
    get_a(4, 30, v); check("R4 out6 w5 -> in6 w4", v, 32'h5A5A_0006);
    put(0, 15, 32'h0BAD_F00D);           // out 7 of window 0, wraps
    get_b(NWIN-1, 31, v); check("R4 wrap out7 w0 -> in7 w7", v, 32'h0BAD_F00D);
    put(3, 24, 32'h3333_0024);           // in 0 of window 3
    get_a(4, 8, v); check("R4 in0 w3 -> out0 w4", v, 32'h3333_0024);
    put(5, 9, 32'h9999_0009);            // out 1 of window 5
    get_b(5, 25, v); check("R4 own ins differ from own outs", v, '0);
  endtask

  task automatic t_locals_r5();
    logic [XLEN-1:0] v;
    put(1, 20, 32'hAAAA_0001);
    put(6, 20, 32'hAAAA_0006);
    get_a(1, 20, v); check("R5 local w1", v, 32'hAAAA_0001);
    get_a(6, 20, v); check("R5 local w6", v, 32'hAAAA_0006);
    get_b(2, 20, v); check("R5 local w2 untouched", v, '0);
  endtask

  task automatic t_globals_r6();
    logic [XLEN-1:0] v;
    put(0, 5, 32'h6060_6060);
    get_a(7, 5, v); check("R6 global seen in w7", v, 32'h6060_6060);
    get_b(3, 5, v); check("R6 global seen in w3", v, 32'h6060_6060);
  endtask

  task automatic t_rdw_r7();
    logic [XLEN-1:0] v;
    put(4, 10, 32'h7000_0001);
    @(negedge clk);
    wr_en = 1'b1; wr_win = WPW'(4); wr_idx = 5'd10; wr_data = 32'h7000_0002;
    get_a(4, 10, v); check("R7 old value during write", v, 32'h7000_0001);
    @(negedge clk);
    wr_en = 1'b0;
    get_a(4, 10, v); check("R7 new value after edge", v, 32'h7000_0002);
  endtask

  task automatic t_comb_r8();
    logic [XLEN-1:0] v;
    @(negedge clk);
    get_b(2, 17, v); check("R8 port B holds", v, 32'h1111_2222);
    get_a(0, 5, v);  check("R8 port A follows index", v, 32'h6060_6060);
    #1 check("R8 port B unaffected by A", rd_data_b, 32'h1111_2222);
    get_a(7, 5, v); check("R8 window change no clock", v, 32'h6060_6060);
    get_a(6, 20, v); check("R8 local via A", v, 32'hAAAA_0006);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset_r1();
    t_zero_r2();
    t_write_r3();
    t_alias_r4();
    t_locals_r5();
    t_globals_r6();
    t_rdw_r7();
    t_comb_r8();
    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule